// File: doc/BRIEF.md
# Stepper Stall Monitor with Four-Sample Torque Averaging

This block watches a stepper motor drive for a stall. Once every electrical half-cycle, a measurement front end supplies a raw 12-bit torque figure together with a one-cycle valid strobe. The block keeps the four most recent figures and averages them. When enabled, it multiplies small averages by eight so that drives with high coil resistance still give usable numbers. It publishes the result as a torque count that holds steady between half-cycles.

Each time the count is published, it is compared against a programmable 12-bit threshold. A count below the threshold is a stall. A stall sets sticky status flags, and it can pull an active-low fault pin low if stall reporting is allowed. Detection runs only while the ripple-control decay mode is selected, the stall enable is set and no other protection fault is present. Leaving that state empties the averaging window but keeps the latched flags. The flags are released only by a clear-faults pulse or by a sleep reset pulse.

Top module: `stall_monitor`

## Requirements
- R1: Detection is active only when `decay_mode` equals 3'b111 (ripple control), `stall_en` is 1, and none of `uv_flt`, `oc_flt`, `ol_flt`, `ot_flt` is high. While it is inactive, strobes are ignored and no stall can be flagged.
- R2: Once the window is full, the unscaled value is the 12-bit floor of the sum of the four most recent accepted measurements divided by four. The newest measurement replaces the oldest.
- R3: `trq_count` takes its new value on the first rising clock edge that samples `meas_valid` high. It keeps that value while no strobe arrives.
- R4: With `scale_en` at 1 and an unscaled average below 500, the published count is that average times 8, capped at 4095. An average of 500 or more, or `scale_en` at 0, is published unchanged.
- R5: An update whose published count is strictly below `stall_thresh` sets `stall_flag`, `stall_seen` and `fault_any` on that same edge. They stay set across later updates of any value. A count equal to the threshold is not a stall.
- R6: `fault_n` is 0 exactly while the stall flags are set and `report_en` is 1. Otherwise it is 1.
- R7: A high `clr_flt` or `sleep_rst` clears all three flags on the next edge. If it coincides with a stalling update, the clear wins, and the flags set again on the next stalling update.
- R8: After reset, or after detection has been inactive, the first three accepted measurements leave `trq_count` at 0 and flag no stall. The fourth publishes the average.
- R9: One edge after detection becomes inactive, the window is emptied and `trq_count` reads 0. Latched flags are kept.
- R10: Reset leaves `trq_count` at 0, all flags at 0 and `fault_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe for a half-cycle measurement |
| meas_val | input | 12 | Raw torque measurement |
| decay_mode | input | 3 | Decay mode select; 3'b111 is ripple control |
| stall_en | input | 1 | Stall detection enable |
| scale_en | input | 1 | Enables ×8 scaling of small averages |
| report_en | input | 1 | Allows a stall to drive `fault_n` |
| stall_thresh | input | 12 | Stall threshold |
| uv_flt | input | 1 | Undervoltage fault present |
| oc_flt | input | 1 | Overcurrent fault present |
| ol_flt | input | 1 | Open-load fault present |
| ot_flt | input | 1 | Thermal shutdown fault present |
| clr_flt | input | 1 | Clear-faults pulse |
| sleep_rst | input | 1 | Sleep reset pulse; clears faults |
| trq_count | output | 12 | Published torque count |
| stall_flag | output | 1 | Stall status flag |
| stall_seen | output | 1 | Latched stall indication |
| fault_any | output | 1 | General fault flag |
| fault_n | output | 1 | Active-low fault pin |

## Verification
A strobe sampled at one rising edge changes the count, and any flag it triggers, at that same edge. Clear pulses and the loss of qualification act one edge after they are sampled. `fault_n` follows `report_en` with no clock at all. The bench drives every input at a falling edge and holds strobes and pulses for one full cycle. It reads the results at the next falling edge, which is exactly one registered stage after the stimulus. Checks on the pin alone are made a short delay after `report_en` changes.

// File: rtl/stall_monitor.sv
module stall_monitor #(
  parameter int W            = 12,
  parameter int DEPTH        = 4,
  parameter int MODE_W       = 3,
  parameter logic [MODE_W-1:0] RIPPLE_MODE = MODE_W'(7),
  parameter int SCALE_CUT    = 500,
  parameter int SCALE_SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_valid,
  input  logic [W-1:0]      meas_val,
  input  logic [MODE_W-1:0] decay_mode,
  input  logic              stall_en,
  input  logic              scale_en,
  input  logic              report_en,
  input  logic [W-1:0]      stall_thresh,
  input  logic              uv_flt,
  input  logic              oc_flt,
  input  logic              ol_flt,
  input  logic              ot_flt,
  input  logic              clr_flt,
  input  logic              sleep_rst,
  output logic [W-1:0]      trq_count,
  output logic              stall_flag,
  output logic              stall_seen,
  output logic              fault_any,
  output logic              fault_n
);
  localparam int LOG   = $clog2(DEPTH);
  localparam int SUM_W = W + LOG;
  localparam int PW    = W + SCALE_SHIFT;
  localparam logic [PW-1:0]  CAP    = PW'((1 << W) - 1);
  localparam logic [LOG:0]   FULL_M = (LOG + 1)'(DEPTH - 1);
  localparam logic [LOG:0]   FULL   = (LOG + 1)'(DEPTH);

  logic [W-1:0]     win [DEPTH-1];
  logic [LOG:0]     fill;
  logic [SUM_W-1:0] sum_nx;
  logic [W-1:0]     avg, scaled, pub;
  logic [PW-1:0]    prod;
  logic             stall_q;

  wire active  = (decay_mode == RIPPLE_MODE) && stall_en &&
                 !(uv_flt || oc_flt || ol_flt || ot_flt);
  wire take    = active && meas_valid;
  wire full_nx = (fill >= FULL_M);
  wire clear   = clr_flt || sleep_rst;
  wire detect  = take && full_nx && (pub < stall_thresh);

  always_comb begin
    sum_nx = SUM_W'(meas_val);
    for (int i = 0; i < DEPTH - 1; i++) sum_nx = sum_nx + SUM_W'(win[i]);
  end

  assign avg    = sum_nx[SUM_W-1:LOG];
  assign prod   = {avg, {SCALE_SHIFT{1'b0}}};
  assign scaled = (prod > CAP) ? {W{1'b1}} : prod[W-1:0];
  assign pub    = (scale_en && (avg < W'(SCALE_CUT))) ? scaled : avg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      trq_count <= '0;
      for (int i = 0; i < DEPTH - 1; i++) win[i] <= '0;
    end else if (!active) begin
      fill      <= '0;
      trq_count <= '0;
      for (int i = 0; i < DEPTH - 1; i++) win[i] <= '0;
    end else if (meas_valid) begin
      for (int i = DEPTH - 2; i > 0; i--) win[i] <= win[i-1];
      win[0] <= meas_val;
      if (fill != FULL) fill <= fill + 1'b1;
      if (full_nx) trq_count <= pub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stall_q <= 1'b0;
    else if (clear)  stall_q <= 1'b0;
    else if (detect) stall_q <= 1'b1;
  end

  assign stall_flag = stall_q;
  assign stall_seen = stall_q;
  assign fault_any  = stall_q;
  assign fault_n    = !(stall_q && report_en);

  p_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_q) |-> $past(active) && $past(meas_valid));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !meas_valid) |=> $stable(trq_count));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !clear) |=> stall_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !stall_q);
  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_q) |-> ($past(fill) >= FULL_M));
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (trq_count == '0));
endmodule

// File: tb/tb_stall_monitor.sv
module tb_stall_monitor;
  localparam time CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        meas_valid = 0;
  logic [11:0] meas_val = 0;
  logic [2:0]  decay_mode = 3'd7;
  logic        stall_en = 1, scale_en = 0, report_en = 0;
  logic [11:0] stall_thresh = 12'd4095;
  logic        uv_flt = 0, oc_flt = 0, ol_flt = 0, ot_flt = 0;
  logic        clr_flt = 0, sleep_rst = 0;
  logic [11:0] trq_count;
  logic        stall_flag, stall_seen, fault_any, fault_n;

  int tests = 0, fails = 0;
  bit done = 0;

  stall_monitor dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int exp);
    chk(req, stall_flag, exp);
    chk(req, stall_seen, exp);
    chk(req, fault_any, exp);
  endtask

  task automatic send(input int v, input bit clr = 0);
    @(negedge clk);
    meas_valid = 1; meas_val = 12'(v); clr_flt = clr;
    @(negedge clk);
    meas_valid = 0; clr_flt = 0;
  endtask

  task automatic pulse_clear(input bit use_sleep);
    @(negedge clk);
    if (use_sleep) sleep_rst = 1; else clr_flt = 1;
    @(negedge clk);
    sleep_rst = 0; clr_flt = 0;
  endtask

  task automatic t_reset;
    chk("R10 count", trq_count, 0);
    chk_flags("R10 flags", 0);
    chk("R10 pin", fault_n, 1);
  endtask

  task automatic t_fill;
    send(100); chk("R8 count", trq_count, 0); chk_flags("R8 nostall", 0);
    send(200); chk("R8 count", trq_count, 0);
    send(300); chk("R8 count", trq_count, 0); chk_flags("R8 nostall", 0);
    stall_thresh = 0;
    send(400); chk("R2 first avg", trq_count, 250);
    repeat (3) @(negedge clk);
    chk("R3 hold", trq_count, 250);
  endtask

  task automatic t_slide;
    send(800);  chk("R2 slide", trq_count, 425);
    send(4095); chk("R2 slide", trq_count, 1398);
    send(4095); send(4095); send(4095);
    chk("R2 max", trq_count, 4095);
  endtask

  task automatic t_scale;
    scale_en = 1;
    send(100); chk("R4 large unscaled", trq_count, 3096);
    send(100); send(100); send(100);
    chk("R4 scaled", trq_count, 800);
    send(500); chk("R4 scaled mid", trq_count, 1600);
    send(500); send(500); send(500);
    chk("R4 cutoff unscaled", trq_count, 500);
    send(499); send(499); send(499); send(499);
    chk("R4 just below", trq_count, 3992);
    scale_en = 0;
  endtask

  task automatic t_stall;
    stall_thresh = 300; report_en = 0;
    send(200); chk("R5 above", trq_count, 424); chk_flags("R5 none", 0);
    send(200); chk("R5 above", trq_count, 349); chk_flags("R5 none", 0);
    send(200); chk("R5 below", trq_count, 274); chk_flags("R5 set", 1);
    chk("R6 unreported", fault_n, 1);
    report_en = 1; #1;
    chk("R6 reported", fault_n, 0);
    send(1000); send(1000); send(1000); send(1000);
    chk("R5 sticky count", trq_count, 1000); chk_flags("R5 sticky", 1);
  endtask

  task automatic t_clear;
    pulse_clear(0);
    chk_flags("R7 clr", 0); chk("R7 pin", fault_n, 1);
    stall_thresh = 1000;
    send(1000); chk_flags("R5 equal", 0);
    stall_thresh = 1001;
    send(1000); chk_flags("R5 just below", 1);
    pulse_clear(1);
    chk_flags("R7 sleep", 0);
    stall_thresh = 4095;
    send(1000, 1);
    chk("R7 coincide count", trq_count, 1000); chk_flags("R7 clear wins", 0);
    send(1000); chk_flags("R7 reassert", 1);
    pulse_clear(0);
    chk_flags("R7 clr", 0);
  endtask

  task automatic gate_try(input string req);
    @(negedge clk);
    send(900); send(900); send(900); send(900);
    chk(req, trq_count, 0); chk_flags(req, 0);
  endtask

  task automatic t_gate;
    stall_thresh = 4095;
    decay_mode = 3'd2; gate_try("R1 mode");   decay_mode = 3'd7;
    stall_en = 0;      gate_try("R1 enable"); stall_en = 1;
    oc_flt = 1;        gate_try("R1 ocp");    oc_flt = 0;
    uv_flt = 1;        gate_try("R1 uvlo");   uv_flt = 0;
    ol_flt = 1;        gate_try("R1 ol");     ol_flt = 0;
    ot_flt = 1;        gate_try("R1 otsd");   ot_flt = 0;
  endtask

  task automatic t_flush;
    send(600); send(600); send(600); send(600);
    chk("R9 pre", trq_count, 600); chk_flags("R9 pre stall", 1);
    @(negedge clk); stall_en = 0;
    @(negedge clk);
    chk("R9 flushed", trq_count, 0); chk_flags("R9 kept", 1);
    stall_en = 1;
    send(700); send(700); send(700);
    chk("R8 refill", trq_count, 0);
    send(700); chk("R8 refill full", trq_count, 700);
    chk_flags("R9 kept", 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fill();
    t_slide();
    t_scale();
    t_stall();
    t_clear();
    t_gate();
    t_flush();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule